// File: doc/BRIEF.md
# Drive DMA Handshake Sequencer

This block runs the drive-side handshake for multiword bus-master DMA. When the drive raises its DMA request and the descriptor walker has the channel running, the block asserts the acknowledge. It then issues read or write strobes, each moving one 16-bit word between the drive data lines and the line buffer. The strobe high time and the recovery time between strobes are counted in clocks. Each channel has a normal timing set, shared with programmed I/O, and a faster set. A per-channel enable bit makes DMA cycles use the fast set, while programmed I/O keeps the normal one.

The drive's request is sampled on the clock edge that ends each strobe. If the request is inactive there, or the walker has dropped its run enable, the acknowledge is released one clock later. The block then waits idle until the drive asks again. A strobe starts only when the line buffer signals that it can take or supply a word.

Top module: `dmaHandshakeSeq`

## Requirements
- R1: During and straight after reset, `dmaAck`, `rdStrobe`, `wrStrobe` and `wordDone` are low and `driveDataOut` and `bufWordOut` are zero.
- R2: From idle, with `runEn` and `dmaReq` high at a clock edge, `dmaAck` is high after that edge. The first strobe rises at the following edge if `bufReady` is high.
- R3: A strobe stays high for exactly the selected active count of clocks. Within a burst it stays low for exactly the selected recovery count before the next strobe, when request, run and buffer permit.
- R4: The timing set is the one for channel `chanSel`. It is the normal set when `fastEn[chanSel]` is 0 and the fast set when it is 1. Counts are packed per channel, channel c in bits [c*CNT_W +: CNT_W]. Any count below 2 acts as 2.
- R5: `dmaReq` is sampled at the edge where the strobe falls. If it is low there, `dmaAck` falls at the next edge and no further strobe occurs.
- R6: After the acknowledge is released it stays low, with no strobe, while `dmaReq` is low. It rises one clock after `dmaReq` returns high (with `runEn` high) once recovery has ended.
- R7: No strobe starts while `bufReady` is low. `dmaAck` is held during the wait, and the strobe rises at the edge where `bufReady` is first seen high.
- R8: Dropping `runEn` during a strobe lets that strobe finish its full width. The acknowledge then falls one clock after the strobe falls. `runEn` low while waiting to start a strobe releases the acknowledge at the next edge.
- R9: `dirToDrive`=1 moves words to the drive on `wrStrobe`. `bufWordIn` is taken at the strobe's rising edge, held on `driveDataOut`, and `wordDone` is high for the first strobe cycle. `dirToDrive`=0 uses `rdStrobe`: `driveDataIn` is captured at the falling edge onto `bufWordOut`, and `wordDone` is high for the first cycle after the fall. The direction is latched per strobe and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable from the descriptor walker; low stops at the next strobe boundary |
| dirToDrive | input | 1 | 1: memory to drive (write strobes), 0: drive to memory (read strobes) |
| chanSel | input | CH_W | Channel whose timing applies |
| fastEn | input | NUM_CH | Per-channel enable of fast timing for DMA cycles |
| pioActive | input | NUM_CH*CNT_W | Normal strobe active counts, packed per channel |
| pioRecover | input | NUM_CH*CNT_W | Normal recovery counts, packed per channel |
| fastActive | input | NUM_CH*CNT_W | Fast strobe active counts, packed per channel |
| fastRecover | input | NUM_CH*CNT_W | Fast recovery counts, packed per channel |
| dmaReq | input | 1 | DMA request from the drive |
| dmaAck | output | 1 | DMA acknowledge to the drive (active high here) |
| rdStrobe | output | 1 | Read strobe to the drive (active high here) |
| wrStrobe | output | 1 | Write strobe to the drive (active high here) |
| driveDataIn | input | DATA_W | Data from the drive |
| driveDataOut | output | DATA_W | Data to the drive |
| bufReady | input | 1 | Line buffer can supply or accept one word |
| bufWordIn | input | DATA_W | Word from the line buffer |
| bufWordOut | output | DATA_W | Word to the line buffer |
| wordDone | output | 1 | One-cycle pulse per word moved |

## Verification
The request sample and the end of the strobe share one edge. The stop from the walker can land on that same edge, as can a drop of `bufReady` at the end of recovery. The bench drives `dmaReq`, `runEn` and `bufReady` so that they change exactly on the cycle before a strobe falls or before recovery completes. It does this first in directed steps and then through a long randomized stretch. A behavioural model that counts high and low clocks predicts, on every clock, when the acknowledge falls, whether the next strobe starts and which word moves. The outputs are compared with that prediction.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARMED,
    SEQ_ACTIVE,
    SEQ_RECOVER
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadActive;
    logic loadRecover;
    logic captureIn;
    logic loadOut;
  } dpCtrl_t;

endpackage

// File: rtl/dmaSeqTiming.sv
module dmaSeqTiming #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 4,
  parameter int CH_W   = 1
) (
  input  logic [CH_W-1:0]         chanSel,
  input  logic [NUM_CH-1:0]       fastEn,
  input  logic [NUM_CH*CNT_W-1:0] pioActive,
  input  logic [NUM_CH*CNT_W-1:0] pioRecover,
  input  logic [NUM_CH*CNT_W-1:0] fastActive,
  input  logic [NUM_CH*CNT_W-1:0] fastRecover,
  output logic [CNT_W-1:0]        actCnt,
  output logic [CNT_W-1:0]        recCnt
);

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);

  logic [CNT_W-1:0] pioActArr  [NUM_CH];
  logic [CNT_W-1:0] pioRecArr  [NUM_CH];
  logic [CNT_W-1:0] fastActArr [NUM_CH];
  logic [CNT_W-1:0] fastRecArr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gUnpack
    assign pioActArr[g]  = pioActive[g*CNT_W +: CNT_W];
    assign pioRecArr[g]  = pioRecover[g*CNT_W +: CNT_W];
    assign fastActArr[g] = fastActive[g*CNT_W +: CNT_W];
    assign fastRecArr[g] = fastRecover[g*CNT_W +: CNT_W];
  end

  logic [CH_W-1:0]  chIdx;
  logic             fastOn;
  logic [CNT_W-1:0] rawAct;
  logic [CNT_W-1:0] rawRec;

  // out-of-range channel numbers fall back to channel 0
  assign chIdx  = (int'(chanSel) < NUM_CH) ? chanSel : '0;
  assign fastOn = fastEn[chIdx];
  assign rawAct = fastOn ? fastActArr[chIdx] : pioActArr[chIdx];
  assign rawRec = fastOn ? fastRecArr[chIdx] : pioRecArr[chIdx];

  assign actCnt = (rawAct < MIN_CNT) ? MIN_CNT : rawAct;
  assign recCnt = (rawRec < MIN_CNT) ? MIN_CNT : rawRec;

endmodule

// File: rtl/dmaSeqDatapath.sv
module dmaSeqDatapath
  import dmaseq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [CNT_W-1:0]  actCnt,
  input  logic [CNT_W-1:0]  recCnt,
  input  logic [DATA_W-1:0] driveDataIn,
  input  logic [DATA_W-1:0] bufWordIn,
  output logic              cntZero,
  output logic [DATA_W-1:0] driveDataOut,
  output logic [DATA_W-1:0] bufWordOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  phaseCnt;
  logic [DATA_W-1:0] outWord;
  logic [DATA_W-1:0] inWord;

  // phase counter: loaded with width-1, zero marks the last cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.loadActive) begin
      phaseCnt <= actCnt - ONE;
    end else if (ctl.loadRecover) begin
      phaseCnt <= recCnt - ONE;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
      inWord  <= '0;
    end else begin
      if (ctl.loadOut)   outWord <= bufWordIn;
      if (ctl.captureIn) inWord  <= driveDataIn;
    end
  end

  assign cntZero      = (phaseCnt == '0);
  assign driveDataOut = outWord;
  assign bufWordOut   = inWord;

endmodule

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    dirToDrive,
  input  logic    dmaReq,
  input  logic    bufReady,
  input  logic    cntZero,
  output logic    dmaAck,
  output logic    rdStrobe,
  output logic    wrStrobe,
  output logic    wordDone,
  output dpCtrl_t ctl
);

  seqState_t state, nState;
  logic ackR, nAck;
  logic strobeR, nStrobe;
  logic dirR, nDir;
  logic contR, nCont;
  logic doneR, nDone;
  logic startAct;

  always_comb begin
    nState   = state;
    nAck     = ackR;
    nStrobe  = strobeR;
    nDir     = dirR;
    nCont    = contR;
    nDone    = 1'b0;
    ctl      = '0;
    startAct = 1'b0;

    case (state)
      SEQ_IDLE: begin
        if (runEn && dmaReq) begin
          nAck   = 1'b1;
          nState = SEQ_ARMED;
        end
      end
      SEQ_ARMED: begin
        if (!runEn) begin
          nAck   = 1'b0;
          nState = SEQ_IDLE;
        end else if (bufReady) begin
          startAct = 1'b1;
        end
      end
      SEQ_ACTIVE: begin
        if (cntZero) begin
          // strobe falls on this edge; request sampled on the same edge
          nStrobe         = 1'b0;
          nState          = SEQ_RECOVER;
          ctl.loadRecover = 1'b1;
          ctl.captureIn   = !dirR;
          nDone           = !dirR;
          nCont           = dmaReq && runEn;
        end
      end
      SEQ_RECOVER: begin
        if (!contR) nAck = 1'b0;
        if (cntZero) begin
          if (!contR) begin
            nState = SEQ_IDLE;
          end else if (!runEn) begin
            nAck   = 1'b0;
            nState = SEQ_IDLE;
          end else if (bufReady) begin
            startAct = 1'b1;
          end else begin
            nState = SEQ_ARMED;
          end
        end
      end
      default: nState = SEQ_IDLE;
    endcase

    if (startAct) begin
      nState         = SEQ_ACTIVE;
      nStrobe        = 1'b1;
      nDir           = dirToDrive;
      ctl.loadActive = 1'b1;
      ctl.loadOut    = dirToDrive;
      nDone          = dirToDrive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      ackR    <= 1'b0;
      strobeR <= 1'b0;
      dirR    <= 1'b0;
      contR   <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      state   <= nState;
      ackR    <= nAck;
      strobeR <= nStrobe;
      dirR    <= nDir;
      contR   <= nCont;
      doneR   <= nDone;
    end
  end

  assign dmaAck   = ackR;
  assign rdStrobe = strobeR && !dirR;
  assign wrStrobe = strobeR && dirR;
  assign wordDone = doneR;

endmodule

// File: rtl/dmaHandshakeSeq.sv
module dmaHandshakeSeq
  import dmaseq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runEn,
  input  logic                    dirToDrive,
  input  logic [CH_W-1:0]         chanSel,
  input  logic [NUM_CH-1:0]       fastEn,
  input  logic [NUM_CH*CNT_W-1:0] pioActive,
  input  logic [NUM_CH*CNT_W-1:0] pioRecover,
  input  logic [NUM_CH*CNT_W-1:0] fastActive,
  input  logic [NUM_CH*CNT_W-1:0] fastRecover,
  input  logic                    dmaReq,
  output logic                    dmaAck,
  output logic                    rdStrobe,
  output logic                    wrStrobe,
  input  logic [DATA_W-1:0]       driveDataIn,
  output logic [DATA_W-1:0]       driveDataOut,
  input  logic                    bufReady,
  input  logic [DATA_W-1:0]       bufWordIn,
  output logic [DATA_W-1:0]       bufWordOut,
  output logic                    wordDone
);

  dpCtrl_t          ctl;
  logic             cntZero;
  logic [CNT_W-1:0] actCnt;
  logic [CNT_W-1:0] recCnt;

  dmaSeqTiming #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_timing (
    .chanSel     (chanSel),
    .fastEn      (fastEn),
    .pioActive   (pioActive),
    .pioRecover  (pioRecover),
    .fastActive  (fastActive),
    .fastRecover (fastRecover),
    .actCnt      (actCnt),
    .recCnt      (recCnt)
  );

  dmaSeqCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .dirToDrive (dirToDrive),
    .dmaReq     (dmaReq),
    .bufReady   (bufReady),
    .cntZero    (cntZero),
    .dmaAck     (dmaAck),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .wordDone   (wordDone),
    .ctl        (ctl)
  );

  dmaSeqDatapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .actCnt       (actCnt),
    .recCnt       (recCnt),
    .driveDataIn  (driveDataIn),
    .bufWordIn    (bufWordIn),
    .cntZero      (cntZero),
    .driveDataOut (driveDataOut),
    .bufWordOut   (bufWordOut)
  );

endmodule

// File: rtl/dmaSeqChecker.sv
module dmaSeqChecker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic dmaReq,
  input logic bufReady,
  input logic dmaAck,
  input logic rdStrobe,
  input logic wrStrobe,
  input logic wordDone
);

  logic strobe;
  assign strobe = rdStrobe || wrStrobe;

  assert_strobe_under_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> dmaAck);

  assert_release_after_idle_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(strobe) && !$past(dmaReq)) |=> !dmaAck);

  assert_ack_needs_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaAck) |-> ($past(dmaReq) && $past(runEn)));

  assert_min_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe) |=> strobe);

  assert_min_recovery_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe) |=> !strobe);

  assert_start_needs_buffer_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe) |-> $past(bufReady));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStrobe, wrStrobe}));

  assert_word_pulse_place_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> ($rose(wrStrobe) || $fell(rdStrobe)));

endmodule

bind dmaHandshakeSeq dmaSeqChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runEn    (runEn),
  .dmaReq   (dmaReq),
  .bufReady (bufReady),
  .dmaAck   (dmaAck),
  .rdStrobe (rdStrobe),
  .wrStrobe (wrStrobe),
  .wordDone (wordDone)
);

// File: tb/sim_dmaHandshakeSeq.sv
`timescale 1ns/1ps
module sim_dmaHandshakeSeq;

  localparam int NCH = 2;
  localparam int CW  = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic dirToDrive = 1'b1;
  logic [0:0] chanSel = '0;
  logic [NCH-1:0] fastEn = '0;
  logic [CW-1:0] pioAct [NCH];
  logic [CW-1:0] pioRec [NCH];
  logic [CW-1:0] fstAct [NCH];
  logic [CW-1:0] fstRec [NCH];
  logic dmaReq = 1'b0;
  logic bufReady = 1'b0;
  logic [DW-1:0] driveDataIn = '0;
  logic [DW-1:0] bufWordIn = '0;
  logic dmaAck, rdStrobe, wrStrobe, wordDone;
  logic [DW-1:0] driveDataOut, bufWordOut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit cmpOn = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmaHandshakeSeq #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dirToDrive(dirToDrive),
    .chanSel(chanSel), .fastEn(fastEn),
    .pioActive({pioAct[1], pioAct[0]}), .pioRecover({pioRec[1], pioRec[0]}),
    .fastActive({fstAct[1], fstAct[0]}), .fastRecover({fstRec[1], fstRec[0]}),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .driveDataIn(driveDataIn), .driveDataOut(driveDataOut),
    .bufReady(bufReady), .bufWordIn(bufWordIn), .bufWordOut(bufWordOut),
    .wordDone(wordDone)
  );

  task automatic check(string req, string what, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, actual, expected, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mPhase;       // 0 idle, 1 waiting for buffer, 2 strobe high, 3 strobe low
  int  mLeft;        // clocks left in the current high/low phase
  bit  mAck, mStrb, mDir, mCont, mDone;
  logic [DW-1:0] mOut, mIn;

  function automatic int pickTime(bit wantAct);
    int ch = int'(chanSel);
    int v;
    if (wantAct) v = fastEn[ch] ? int'(fstAct[ch]) : int'(pioAct[ch]);
    else         v = fastEn[ch] ? int'(fstRec[ch]) : int'(pioRec[ch]);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic modelStart();
    mStrb = 1; mPhase = 2; mLeft = pickTime(1); mDir = dirToDrive;
    if (dirToDrive) begin mOut = bufWordIn; mDone = 1; end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mAck = 0; mStrb = 0; mDir = 0; mCont = 0; mDone = 0;
      mOut = '0; mIn = '0;
    end else begin
      mDone = 0;
      case (mPhase)
        0: if (runEn && dmaReq) begin mAck = 1; mPhase = 1; end
        1: if (!runEn) begin mAck = 0; mPhase = 0; end
           else if (bufReady) modelStart();
        2: begin
          mLeft--;
          if (mLeft == 0) begin
            mStrb = 0; mPhase = 3; mLeft = pickTime(0);
            mCont = dmaReq && runEn;
            if (!mDir) begin mIn = driveDataIn; mDone = 1; end
          end
        end
        default: begin
          if (!mCont) mAck = 0;
          mLeft--;
          if (mLeft == 0) begin
            if (!mCont) mPhase = 0;
            else if (!runEn) begin mAck = 0; mPhase = 0; end
            else if (bufReady) modelStart();
            else mPhase = 1;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmpOn && rstN && !finished) begin
      check("R5", "dmaAck vs model", int'(dmaAck), int'(mAck));
      check("R3", "wrStrobe vs model", int'(wrStrobe), int'(mStrb && mDir));
      check("R3", "rdStrobe vs model", int'(rdStrobe), int'(mStrb && !mDir));
      check("R9", "wordDone vs model", int'(wordDone), int'(mDone));
      check("R9", "driveDataOut vs model", int'(driveDataOut), int'(mOut));
      check("R9", "bufWordOut vs model", int'(bufWordOut), int'(mIn));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL R2 watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- directed helpers ----------------
  task automatic waitStrobe(output int lat);
    lat = 0;
    while (!(rdStrobe || wrStrobe) && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic countHigh(output int n);
    n = 0;
    while ((rdStrobe || wrStrobe) && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (!(rdStrobe || wrStrobe) && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    int bad;
    for (int c = 0; c < NCH; c++) begin
      pioAct[c] = 4'd4; pioRec[c] = 4'd3; fstAct[c] = 4'd2; fstRec[c] = 4'd2;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    check("R1", "dmaAck in reset", int'(dmaAck), 0);
    check("R1", "strobes in reset", int'(rdStrobe || wrStrobe), 0);
    rstN = 1'b1;
    cmpOn = 1;
    @(negedge clk);
    check("R1", "wordDone after reset", int'(wordDone), 0);
    check("R1", "driveDataOut after reset", int'(driveDataOut), 0);
    check("R1", "bufWordOut after reset", int'(bufWordOut), 0);

    // R2 / R3: normal timing 4 active, 3 recovery, write direction
    bufWordIn = 16'h1234; dirToDrive = 1; bufReady = 1; runEn = 1; dmaReq = 1;
    n = 0;
    while (!dmaAck && n < 50) begin @(negedge clk); n++; end
    check("R2", "clocks to acknowledge", n, 1);
    waitStrobe(n);
    check("R2", "clocks from ack to strobe", n, 1);
    check("R9", "write word on drive bus", int'(driveDataOut), 16'h1234);
    check("R9", "wordDone on write strobe", int'(wordDone), 1);
    countHigh(n);
    check("R3", "normal active width", n, 4);
    countLow(n);
    check("R3", "normal recovery width", n, 3);

    // R5: request drops during strobe, sampled at its fall
    dmaReq = 0;
    countHigh(n);
    check("R5", "ack still high the clock strobe falls", int'(dmaAck), 1);
    @(negedge clk);
    check("R5", "ack released next clock", int'(dmaAck), 0);

    // R6: stays released while request low
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (dmaAck || rdStrobe || wrStrobe) bad++;
    end
    check("R6", "activity while request low", bad, 0);
    dmaReq = 1;
    @(negedge clk);
    check("R6", "ack on renewed request", int'(dmaAck), 1);

    // R4: fast timing on channel 0
    fastEn = 2'b01;
    waitStrobe(n);
    countHigh(n);
    check("R4", "fast active width", n, 2);
    countLow(n);
    check("R4", "fast recovery width", n, 2);

    // R7: buffer not ready holds the next strobe
    bufReady = 0;
    countHigh(n);
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (rdStrobe || wrStrobe || !dmaAck) bad++;
    end
    check("R7", "strobe or ack loss while buffer busy", bad, 0);
    bufReady = 1;
    @(negedge clk);
    check("R7", "strobe after buffer ready", int'(wrStrobe), 1);

    // R8: stop from the walker during a strobe
    runEn = 0;
    countHigh(n);
    check("R8", "stopped strobe full width", n, 2);
    check("R8", "ack the clock strobe falls", int'(dmaAck), 1);
    @(negedge clk);
    check("R8", "ack after stop", int'(dmaAck), 0);

    // R4: clamp of counts below 2 on channel 1
    chanSel = 1; fastEn = 2'b00; pioAct[1] = 4'd0; pioRec[1] = 4'd1; runEn = 1;
    waitStrobe(n);
    countHigh(n);
    check("R4", "clamped active width", n, 2);
    countLow(n);
    check("R4", "clamped recovery width", n, 2);

    // R9: read direction
    dirToDrive = 0; driveDataIn = 16'hA5C3;
    countHigh(n);
    countLow(n);
    check("R9", "read strobe used", int'(rdStrobe && !wrStrobe), 1);
    countHigh(n);
    check("R9", "wordDone after read fall", int'(wordDone), 1);
    check("R9", "captured drive word", int'(bufWordOut), 16'hA5C3);

    // mixed stimulus, judged by the model every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      dmaReq      = ($urandom_range(0, 3) != 0);
      bufReady    = ($urandom_range(0, 4) != 0);
      runEn       = ($urandom_range(0, 9) != 0);
      dirToDrive  = $urandom_range(0, 1);
      driveDataIn = DW'($urandom);
      bufWordIn   = DW'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        chanSel = $urandom_range(0, 1);
        fastEn  = NCH'($urandom_range(0, 3));
        for (int c = 0; c < NCH; c++) begin
          pioAct[c] = CW'($urandom_range(0, 7)); pioRec[c] = CW'($urandom_range(0, 7));
          fstAct[c] = CW'($urandom_range(0, 4)); fstRec[c] = CW'($urandom_range(0, 4));
        end
      end
    end
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule